// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block is the host-side register interface of a parallel printer-style port. A host reaches it through a small synchronous bus that carries an address, a one-cycle write or read strobe, an access size and 32-bit write data, and it answers with a one-cycle done pulse and read data. The block holds the byte driven onto the port's data lines, the control byte driven onto the port's control lines, and a sticky timeout flag. It also samples the port's data and status lines when the host reads them.

Two register offsets start handshake transfers toward an attached peripheral. One carries an address byte and one carries data. Each byte of such a transfer is offered on a request/acknowledge pair, and a transfer may move 1, 2 or 4 bytes. A transfer only starts when the control byte holds an exact pattern that selects its direction. When the peripheral does not answer in time, the transfer is abandoned and the sticky flag is raised. An upper register window answers reads with all ones and drops writes.

Top module: `pport_regif`

## Requirements
- R1: Address bit 3 selects the upper window. Every read there returns all ones of the access width, and every write there is dropped. In the lower window only bits 2:0 pick a register: 0 data, 1 status, 2 control, 3 handshake address, 4 handshake data. Offsets 5 to 7 read as all ones of the access width and drop writes.
- R2: A write to control (offset 2) stores the written byte ORed with 0xC0. The stored byte drives `ctrlOut` and is returned by control reads.
- R3: A data read (offset 0) returns the live `periphDataIn` pins when control bit 5 (direction) is set, and the output latch when it is clear.
- R4: A data write whose byte differs from the output latch updates `dataOut` and pulses `dataStb` for one cycle. An equal byte changes nothing and gives no pulse. A control write that leaves the stored byte unchanged gives no `ctrlStb` pulse; one that changes it pulses `ctrlStb` for one cycle.
- R5: A write to offset 3 or 4 starts a transfer only when (control AND 0x2F) equals 0x04. Otherwise the write is dropped: no request is raised and nothing else changes.
- R6: A read of offset 3 or 4 starts a transfer only when (control AND 0x2F) equals 0x24. Otherwise it returns all ones of the access width: 0xFF for size 0, 0xFFFF for size 1, 0xFFFFFFFF for size 2 or 3.
- R7: Transfers on offset 4 move 1, 2 or 4 bytes for size 0, 1 or 2/3, least significant byte first. Transfers on offset 3 always move one byte, and their reads return 8 bits.
- R8: `eppReq` stays high while a transfer runs, and each cycle in which `eppAck` is high completes one byte. If a byte gets no acknowledge within `TMO_CYCLES` request cycles, the transfer ends and the sticky timeout flag is set. Bytes not received read as 0xFF.
- R9: A status read (offset 1) returns `statusIn` with bit 0 replaced by the sticky timeout flag.
- R10: A status write with bit 0 set clears the timeout flag. A status write with bit 0 clear leaves the flag set. Status writes change nothing else.
- R11: Accesses that start no transfer raise `busDone` one cycle after the strobe. A transfer raises `busDone` one cycle after the edge on which its last byte is acknowledged or its timeout expires.
- R12: After reset `dataOut`, `ctrlOut`, the control read value and the timeout flag are zero, and `eppReq`, `dataStb`, `ctrlStb` and `busDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address; MSB picks the upper window |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busDone |
| busDone | output | 1 | One-cycle completion pulse |
| dataOut | output | 8 | Output data latch toward the port |
| dataStb | output | 1 | Pulse when dataOut changes |
| periphDataIn | input | 8 | Port data lines as seen by the host |
| ctrlOut | output | 8 | Stored control byte |
| ctrlStb | output | 1 | Pulse when ctrlOut changes |
| statusIn | input | 8 | Live port status lines |
| eppReq | output | 1 | Handshake byte request |
| eppIsAddr | output | 1 | Current transfer targets the address register |
| eppWrite | output | 1 | Current transfer direction is host to peripheral |
| eppWdata | output | 8 | Byte offered to the peripheral |
| eppRdata | input | 8 | Byte returned by the peripheral |
| eppAck | input | 1 | Peripheral acknowledge, one cycle per byte |

## Verification
An access that starts no transfer sets its latch and strobe outputs on the edge that samples the strobe, and its done pulse and read data appear in the next cycle. A transfer of n bytes, each answered after d idle request cycles, completes n*(d+1)+1 cycles after the strobe. A first-byte timeout completes TMO_CYCLES+1 cycles after it. The bench drives the strobe at a falling edge, counts falling edges until `busDone`, and compares that count with these formulas. A reference model of the latches is applied one time unit after each rising edge and compared with the outputs a little later in every cycle. The strobes therefore match in exactly the cycle after the strobing edge.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_EADR = 3'd3;
  localparam logic [2:0] OFF_EDAT = 3'd4;

  localparam int         CTRL_DIR_BIT   = 5;
  localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR_PAT    = 8'h04;
  localparam logic [7:0] GATE_RD_PAT    = 8'h24;
  localparam logic [7:0] CTRL_FORCED    = 8'hC0;
  localparam int         STAT_TMO_BIT   = 0;

  typedef enum logic [0:0] {XS_IDLE = 1'b0, XS_XFER = 1'b1} xferState_e;

  typedef struct packed {
    logic       wrData;
    logic       wrCtrl;
    logic       wrStat;
    logic       rdImm;
    logic       eppInit;
    logic       eppCap;
    logic [1:0] eppIdx;
    logic       setTmo;
    logic       eppResp;
  } regStrobe_t;

  function automatic logic [31:0] widthOnes(input logic [1:0] sz);
    case (sz)
      2'd0:    widthOnes = 32'h0000_00FF;
      2'd1:    widthOnes = 32'h0000_FFFF;
      default: widthOnes = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] lastByteIdx(input logic [1:0] sz);
    case (sz)
      2'd0:    lastByteIdx = 2'd0;
      2'd1:    lastByteIdx = 2'd1;
      default: lastByteIdx = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/pport_tmo.sv
module pport_tmo #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cntQ <= '0;
    else if (!run)         cntQ <= '0;
    else if (cntQ != LAST) cntQ <= cntQ + 1'b1;
  end

  assign expired = run && (cntQ == LAST);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= LAST);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cntQ == '0));

endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  input  logic              eppAck,
  input  logic              gateWrOk,
  input  logic              gateRdOk,
  input  logic              tmoExpired,
  output regStrobe_t        stb,
  output logic              tmoRun,
  output logic [1:0]        xSize,
  output logic              busDone,
  output logic              eppReq,
  output logic              eppIsAddr,
  output logic              eppWrite,
  output logic [7:0]        eppWdata
);
  xferState_e  stQ;
  logic [1:0]  idxQ;
  logic [1:0]  lastIdxQ;
  logic        wrQ;
  logic        isAddrQ;
  logic [1:0]  sizeQ;
  logic [31:0] wdQ;
  logic        doneQ;

  logic       accept, inUpper, isWr, eppOff, eppGo, isLast, ackNow, tmoNow;
  logic [2:0] off;

  assign inUpper = busAddr[ADDR_W-1];
  assign off     = busAddr[2:0];
  assign accept  = (stQ == XS_IDLE) && (busWr || busRd);
  assign isWr    = busWr;
  assign eppOff  = !inUpper && ((off == OFF_EADR) || (off == OFF_EDAT));
  assign eppGo   = accept && eppOff && (isWr ? gateWrOk : gateRdOk);
  assign isLast  = (idxQ == lastIdxQ);
  assign ackNow  = (stQ == XS_XFER) && eppAck;
  assign tmoNow  = (stQ == XS_XFER) && !eppAck && tmoExpired;

  always_comb begin
    stb         = '0;
    stb.wrData  = accept && isWr && !inUpper && (off == OFF_DATA);
    stb.wrCtrl  = accept && isWr && !inUpper && (off == OFF_CTRL);
    stb.wrStat  = accept && isWr && !inUpper && (off == OFF_STAT);
    stb.rdImm   = accept && !isWr && !eppGo;
    stb.eppInit = eppGo;
    stb.eppCap  = ackNow && !wrQ;
    stb.eppIdx  = idxQ;
    stb.setTmo  = tmoNow;
    stb.eppResp = ((ackNow && isLast) || tmoNow) && !wrQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ      <= XS_IDLE;
      idxQ     <= '0;
      lastIdxQ <= '0;
      wrQ      <= 1'b0;
      isAddrQ  <= 1'b0;
      sizeQ    <= '0;
      wdQ      <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= (accept && !eppGo) || (ackNow && isLast) || tmoNow;
      case (stQ)
        XS_IDLE: begin
          if (eppGo) begin
            stQ      <= XS_XFER;
            idxQ     <= '0;
            wrQ      <= isWr;
            isAddrQ  <= (off == OFF_EADR);
            lastIdxQ <= (off == OFF_EDAT) ? lastByteIdx(busSize) : 2'd0;
            sizeQ    <= (off == OFF_EDAT) ? busSize : 2'd0;
            wdQ      <= busWdata;
          end
        end
        default: begin
          if (ackNow) begin
            if (isLast) stQ <= XS_IDLE;
            else        idxQ <= idxQ + 2'd1;
          end else if (tmoNow) begin
            stQ <= XS_IDLE;
          end
        end
      endcase
    end
  end

  assign busDone   = doneQ;
  assign eppReq    = (stQ == XS_XFER);
  assign eppWrite  = wrQ;
  assign eppIsAddr = isAddrQ;
  assign eppWdata  = wdQ[{idxQ, 3'b000} +: 8];
  assign tmoRun    = (stQ == XS_XFER) && !eppAck;
  assign xSize     = sizeQ;

  // R5 R6
  epp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eppReq) |-> $past(busWr ? gateWrOk : gateRdOk));

  // R8
  req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eppReq) |-> ($past(eppAck) || $past(tmoExpired)));

  // R11
  xfer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eppReq) |-> busDone);

endmodule

// File: rtl/pport_dp.sv
module pport_dp
  import pport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  regStrobe_t  stb,
  input  logic        winUpper,
  input  logic [2:0]  regOff,
  input  logic [1:0]  accSize,
  input  logic [1:0]  xSize,
  input  logic [7:0]  wrByte,
  input  logic [7:0]  periphDataIn,
  input  logic [7:0]  statusIn,
  input  logic [7:0]  eppRdata,
  output logic [7:0]  dataOut,
  output logic        dataStb,
  output logic [7:0]  ctrlOut,
  output logic        ctrlStb,
  output logic        gateWrOk,
  output logic        gateRdOk,
  output logic [31:0] busRdata
);
  logic [7:0]  outQ, ctrlQ;
  logic        tmoQ, dataStbQ, ctrlStbQ;
  logic [31:0] bufQ, bufNext, rdQ, immRd;
  logic [7:0]  ctrlNew;
  logic        dirSet, clrTmo;

  assign dirSet   = ctrlQ[CTRL_DIR_BIT];
  assign gateWrOk = (ctrlQ & CTRL_GATE_MASK) == GATE_WR_PAT;
  assign gateRdOk = (ctrlQ & CTRL_GATE_MASK) == GATE_RD_PAT;
  assign ctrlNew  = wrByte | CTRL_FORCED;
  assign clrTmo   = stb.wrStat && wrByte[STAT_TMO_BIT];

  always_comb begin
    if (winUpper) begin
      immRd = widthOnes(accSize);
    end else begin
      case (regOff)
        OFF_DATA: immRd = {24'b0, (dirSet ? periphDataIn : outQ)};
        OFF_STAT: immRd = {24'b0, (statusIn & 8'hFE) | {7'b0, tmoQ}};
        OFF_CTRL: immRd = {24'b0, ctrlQ};
        default:  immRd = widthOnes(accSize);
      endcase
    end
  end

  always_comb begin
    bufNext = bufQ;
    if (stb.eppCap) bufNext[{stb.eppIdx, 3'b000} +: 8] = eppRdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outQ     <= '0;
      ctrlQ    <= '0;
      tmoQ     <= 1'b0;
      dataStbQ <= 1'b0;
      ctrlStbQ <= 1'b0;
      bufQ     <= '1;
      rdQ      <= '0;
    end else begin
      dataStbQ <= 1'b0;
      ctrlStbQ <= 1'b0;
      if (stb.wrData && (wrByte != outQ)) begin
        outQ     <= wrByte;
        dataStbQ <= 1'b1;
      end
      if (stb.wrCtrl && (ctrlNew != ctrlQ)) begin
        ctrlQ    <= ctrlNew;
        ctrlStbQ <= 1'b1;
      end
      if (stb.setTmo)  tmoQ <= 1'b1;
      else if (clrTmo) tmoQ <= 1'b0;
      if (stb.eppInit)     bufQ <= '1;
      else if (stb.eppCap) bufQ <= bufNext;
      if (stb.rdImm)        rdQ <= immRd;
      else if (stb.eppResp) rdQ <= bufNext & widthOnes(xSize);
    end
  end

  assign dataOut  = outQ;
  assign dataStb  = dataStbQ;
  assign ctrlOut  = ctrlQ;
  assign ctrlStb  = ctrlStbQ;
  assign busRdata = rdQ;

  // R2
  ctrl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlQ != 8'h00) |-> (ctrlQ[7:6] == 2'b11));

  // R10
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmoQ && !clrTmo) |=> tmoQ);

  // R4
  data_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataStbQ |-> (outQ != $past(outQ)));

  // R4
  ctrl_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStbQ |-> (ctrlQ != $past(ctrlQ)));

endmodule

// File: rtl/pport_regif.sv
module pport_regif
  import pport_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int TMO_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busDone,
  output logic [7:0]        dataOut,
  output logic              dataStb,
  input  logic [7:0]        periphDataIn,
  output logic [7:0]        ctrlOut,
  output logic              ctrlStb,
  input  logic [7:0]        statusIn,
  output logic              eppReq,
  output logic              eppIsAddr,
  output logic              eppWrite,
  output logic [7:0]        eppWdata,
  input  logic [7:0]        eppRdata,
  input  logic              eppAck
);
  regStrobe_t stb;
  logic       gateWrOk, gateRdOk, tmoRun, tmoExpired;
  logic [1:0] xSize;

  pport_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busSize(busSize), .busWdata(busWdata),
    .eppAck(eppAck), .gateWrOk(gateWrOk), .gateRdOk(gateRdOk),
    .tmoExpired(tmoExpired), .stb(stb), .tmoRun(tmoRun), .xSize(xSize),
    .busDone(busDone), .eppReq(eppReq), .eppIsAddr(eppIsAddr),
    .eppWrite(eppWrite), .eppWdata(eppWdata)
  );

  pport_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .winUpper(busAddr[ADDR_W-1]), .regOff(busAddr[2:0]),
    .accSize(busSize), .xSize(xSize), .wrByte(busWdata[7:0]),
    .periphDataIn(periphDataIn), .statusIn(statusIn), .eppRdata(eppRdata),
    .dataOut(dataOut), .dataStb(dataStb), .ctrlOut(ctrlOut), .ctrlStb(ctrlStb),
    .gateWrOk(gateWrOk), .gateRdOk(gateRdOk), .busRdata(busRdata)
  );

  pport_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmoRun), .expired(tmoExpired)
  );

endmodule

// File: tb/tb_pport_regif.sv
module tb_pport_regif;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busDone, dataStb, ctrlStb, eppReq, eppIsAddr, eppWrite;
  logic [7:0]  dataOut, ctrlOut, eppWdata;
  logic [7:0]  periphDataIn = '0, statusIn = '0, eppRdata = '0;
  logic        eppAck = 1'b0;

  int checks = 0, failures = 0;
  bit running = 0, done = 0;

  logic [7:0] mOut = '0, mCtrl = '0, nOut, nCtrl;
  bit eDS = 0, eCS = 0, nDS, nCS, applyPending = 0;

  int  ackDelay = 0, ackBudget = 1000, waitCnt = 0;
  logic [7:0] rdQueue[$];
  logic [7:0] wrLog[$];
  bit  addrLog[$];

  pport_regif #(.ADDR_W(4), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .busDone(busDone),
    .dataOut(dataOut), .dataStb(dataStb), .periphDataIn(periphDataIn),
    .ctrlOut(ctrlOut), .ctrlStb(ctrlStb), .statusIn(statusIn),
    .eppReq(eppReq), .eppIsAddr(eppIsAddr), .eppWrite(eppWrite),
    .eppWdata(eppWdata), .eppRdata(eppRdata), .eppAck(eppAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // peripheral responder
  always @(negedge clk) begin
    if (eppReq && ackBudget > 0) begin
      if (waitCnt >= ackDelay) begin
        eppAck = 1'b1;
        eppRdata = (rdQueue.size() > 0) ? rdQueue.pop_front() : 8'h00;
        if (eppWrite) begin wrLog.push_back(eppWdata); addrLog.push_back(eppIsAddr); end
        ackBudget--;
        waitCnt = 0;
      end else begin
        eppAck = 1'b0;
        waitCnt++;
      end
    end else begin
      eppAck = 1'b0;
      waitCnt = 0;
    end
  end

  // reference model apply, just after each edge
  always @(posedge clk) begin
    #1;
    if (applyPending) begin
      mOut = nOut; mCtrl = nCtrl; eDS = nDS; eCS = nCS; applyPending = 0;
    end else begin
      eDS = 0; eCS = 0;
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #3;
    if (running) begin
      check(dataOut == mOut, "R4", "dataOut", {24'b0, dataOut}, {24'b0, mOut});
      check(ctrlOut == mCtrl, "R2", "ctrlOut", {24'b0, ctrlOut}, {24'b0, mCtrl});
      check(dataStb == eDS, "R4", "dataStb", {31'b0, dataStb}, {31'b0, eDS});
      check(ctrlStb == eCS, "R4", "ctrlStb", {31'b0, ctrlStb}, {31'b0, eCS});
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    logic [7:0] v;
    @(negedge clk);
    nOut = mOut; nCtrl = mCtrl; nDS = 0; nCS = 0;
    if (wr && !a[3]) begin
      if (a[2:0] == 3'd0 && wd[7:0] != mOut) begin nOut = wd[7:0]; nDS = 1; end
      if (a[2:0] == 3'd2) begin
        v = wd[7:0] | 8'hC0;
        if (v != mCtrl) begin nCtrl = v; nCS = 1; end
      end
    end
    applyPending = 1;
    busAddr = a; busSize = sz; busWdata = wd; busWr = wr; busRd = !wr;
    @(negedge clk);
    busWr = 0; busRd = 0; lat = 1;
    while (!busDone && lat < 500) begin @(negedge clk); lat++; end
    rd = busRdata;
  endtask

  task automatic wrChk(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] wd,
                       input int expLat, input string req);
    logic [31:0] rd; int lat;
    access(1'b1, a, sz, wd, rd, lat);
    check(lat == expLat, req, "write latency", lat, expLat);
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp,
                       input int expLat, input string req);
    logic [31:0] rd; int lat;
    access(1'b0, a, sz, 32'h0, rd, lat);
    check(lat == expLat, req, "read latency", lat, expLat);
    check(rd == exp, req, "read data", rd, exp);
  endtask

  task automatic logChk(input logic [7:0] b, input bit isAddr, input string req);
    if (wrLog.size() == 0) begin
      check(1'b0, req, "peripheral byte missing", 0, {24'b0, b});
    end else begin
      logic [7:0] g; bit ga;
      g = wrLog.pop_front(); ga = addrLog.pop_front();
      check(g == b, req, "peripheral byte", {24'b0, g}, {24'b0, b});
      check(ga == isAddr, req, "address flag", {31'b0, ga}, {31'b0, isAddr});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    statusIn = 8'hA5;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busDone == 0 && eppReq == 0 && dataStb == 0 && ctrlStb == 0, "R12",
          "reset outputs", {28'b0, busDone, eppReq, dataStb, ctrlStb}, 0);
    check(dataOut == 0 && ctrlOut == 0, "R12", "reset latches",
          {16'b0, dataOut, ctrlOut}, 0);
    rst_n = 1'b1;
    running = 1;
    rdChk(4'd2, 2'd0, 32'h00, 1, "R12");
    rdChk(4'd1, 2'd0, 32'hA4, 1, "R9");
    rdChk(4'd0, 2'd0, 32'h00, 1, "R3");

    // R4 data latch and strobe suppression
    wrChk(4'd0, 2'd0, 32'h0000_003C, 1, "R4");
    wrChk(4'd0, 2'd0, 32'hFFFF_FF3C, 1, "R4");
    rdChk(4'd0, 2'd0, 32'h3C, 1, "R3");

    // R2 control forcing
    wrChk(4'd2, 2'd0, 32'h04, 1, "R2");
    rdChk(4'd2, 2'd0, 32'hC4, 1, "R2");
    wrChk(4'd2, 2'd0, 32'h04, 1, "R4");
    wrChk(4'd2, 2'd0, 32'hC4, 1, "R4");

    // R5 R7 R11 handshake writes
    wrChk(4'd3, 2'd2, 32'hAABB_CC5A, 2, "R7");
    logChk(8'h5A, 1'b1, "R7");
    check(wrLog.size() == 0, "R7", "address write byte count", wrLog.size(), 0);
    wrChk(4'd4, 2'd2, 32'h1122_3344, 5, "R7");
    logChk(8'h44, 1'b0, "R7"); logChk(8'h33, 1'b0, "R7");
    logChk(8'h22, 1'b0, "R7"); logChk(8'h11, 1'b0, "R7");
    wrChk(4'd4, 2'd1, 32'h0000_BEEF, 3, "R7");
    logChk(8'hEF, 1'b0, "R7"); logChk(8'hBE, 1'b0, "R7");
    ackDelay = 2;
    wrChk(4'd4, 2'd0, 32'h77, 4, "R11");
    logChk(8'h77, 1'b0, "R11");
    wrChk(4'd4, 2'd1, 32'h0000_1234, 7, "R11");
    logChk(8'h34, 1'b0, "R11"); logChk(8'h12, 1'b0, "R11");
    ackDelay = 0;

    // R5 gate refusal
    wrChk(4'd2, 2'd0, 32'h05, 1, "R5");
    wrChk(4'd4, 2'd2, 32'hDEAD_BEEF, 1, "R5");
    wrChk(4'd3, 2'd0, 32'h99, 1, "R5");
    wrChk(4'd2, 2'd0, 32'h24, 1, "R5");
    wrChk(4'd4, 2'd0, 32'h66, 1, "R5");
    check(wrLog.size() == 0, "R5", "refused writes reached peripheral", wrLog.size(), 0);

    // R3 input path with direction set
    periphDataIn = 8'h9D;
    rdChk(4'd0, 2'd0, 32'h9D, 1, "R3");

    // R6 R7 handshake reads
    rdQueue.push_back(8'h01); rdQueue.push_back(8'h02);
    rdQueue.push_back(8'h03); rdQueue.push_back(8'h04);
    rdChk(4'd4, 2'd2, 32'h0403_0201, 5, "R7");
    rdQueue.push_back(8'hA1); rdQueue.push_back(8'hB2);
    rdChk(4'd4, 2'd1, 32'h0000_B2A1, 3, "R7");
    rdQueue.push_back(8'h7E);
    rdChk(4'd3, 2'd2, 32'h0000_007E, 2, "R7");
    ackDelay = 1;
    rdQueue.push_back(8'h5C);
    rdChk(4'd4, 2'd0, 32'h5C, 3, "R11");
    ackDelay = 0;

    // R6 read gate refusal
    wrChk(4'd2, 2'd0, 32'h26, 1, "R6");
    rdChk(4'd4, 2'd2, 32'hFFFF_FFFF, 1, "R6");
    rdChk(4'd4, 2'd1, 32'h0000_FFFF, 1, "R6");
    rdChk(4'd3, 2'd0, 32'h0000_00FF, 1, "R6");
    wrChk(4'd2, 2'd0, 32'h04, 1, "R6");
    rdChk(4'd4, 2'd0, 32'h0000_00FF, 1, "R6");

    // R8 timeout, full and partial
    wrChk(4'd2, 2'd0, 32'h24, 1, "R8");
    statusIn = 8'hA4;
    ackBudget = 0;
    rdChk(4'd4, 2'd2, 32'hFFFF_FFFF, TMO + 1, "R8");
    rdChk(4'd1, 2'd0, 32'hA5, 1, "R9");
    // R10 write without bit 0 keeps flag
    wrChk(4'd1, 2'd0, 32'hFE, 1, "R10");
    rdChk(4'd1, 2'd0, 32'hA5, 1, "R10");
    wrChk(4'd1, 2'd0, 32'h01, 1, "R10");
    rdChk(4'd1, 2'd0, 32'hA4, 1, "R10");
    ackBudget = 2;
    rdQueue.push_back(8'h10); rdQueue.push_back(8'h20);
    rdChk(4'd4, 2'd2, 32'hFFFF_2010, TMO + 3, "R8");
    rdChk(4'd1, 2'd0, 32'hA5, 1, "R8");
    wrChk(4'd1, 2'd0, 32'h01, 1, "R10");
    wrChk(4'd2, 2'd0, 32'h04, 1, "R8");
    ackBudget = 0;
    wrChk(4'd4, 2'd0, 32'h42, TMO + 1, "R8");
    ackBudget = 1000;
    rdChk(4'd1, 2'd0, 32'hA5, 1, "R8");
    statusIn = 8'h5B;
    rdChk(4'd1, 2'd0, 32'h5B, 1, "R9");
    wrChk(4'd1, 2'd0, 32'h01, 1, "R10");
    rdChk(4'd1, 2'd0, 32'h5A, 1, "R9");

    // R1 upper window and unused offsets
    wrChk(4'd10, 2'd0, 32'h00, 1, "R1");
    wrChk(4'd8, 2'd0, 32'h55, 1, "R1");
    rdChk(4'd8, 2'd2, 32'hFFFF_FFFF, 1, "R1");
    rdChk(4'd10, 2'd0, 32'h0000_00FF, 1, "R1");
    rdChk(4'd12, 2'd1, 32'h0000_FFFF, 1, "R1");
    wrChk(4'd6, 2'd0, 32'h11, 1, "R1");
    rdChk(4'd5, 2'd0, 32'h0000_00FF, 1, "R1");
    rdChk(4'd7, 2'd2, 32'hFFFF_FFFF, 1, "R1");
    rdChk(4'd2, 2'd0, 32'hC4, 1, "R1");
    check(wrLog.size() == 0, "R1", "stray peripheral writes", wrLog.size(), 0);

    repeat (3) @(negedge clk);
    running = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule